// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous pipelined memory that moves data in bursts of four beats. On a rising clock edge it takes a start address from either of two active-low address strobes. One strobe is meant for a processor and the other for a cache controller. On later edges, each low level on the active-low advance input moves it one beat along the burst. The full word address is available on `word_addr` directly after the edge that loads or steps it. `burst_start` is high for the one cycle in which a freshly loaded start address is shown.

Only the two least significant address bits change during a burst. They follow one of two orders. In linear order the low bits count up by one and wrap modulo four. In interleaved order the low bits of beat k are the starting low bits XOR k. The order is taken from `order_sel` at the moment of the load and is kept for that whole burst. The processor strobe has priority over the controller strobe. The processor strobe counts only while the active-low chip select `sel_n` is low.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer clears itself. After that edge `word_addr` is 0 and `burst_start` is 0, and the stored order is linear.
- R2: If `strb_proc_n` is low and `sel_n` is low at a rising edge, `addr_in` is loaded. After that edge `word_addr` equals the sampled `addr_in` and `burst_start` is 1.
- R3: If the processor strobe is not effective (it is high, or `sel_n` is high) and `strb_ctrl_n` is low at a rising edge, `addr_in` is loaded in the same way. After that edge `word_addr` equals the sampled `addr_in` and `burst_start` is 1.
- R4: If both strobes are low in the same cycle, exactly one load of the sampled `addr_in` takes place. This holds whether `sel_n` is low, so the processor strobe wins, or high, so the controller strobe loads instead.
- R5: A low `strb_proc_n` while `sel_n` is high has no effect on its own. With `strb_ctrl_n` high, the address holds if `adv_n` is high and steps if `adv_n` is low, and `burst_start` stays 0.
- R6: In linear order (`order_sel` = 0 at load), each edge with `adv_n` low and no load changes the low two bits of `word_addr` from v to (v+1) mod 4.
- R7: In interleaved order (`order_sel` = 1 at load), the low two bits at beat k equal the loaded low bits XOR (k mod 4).
- R8: A change of `order_sel` between loads has no effect on the current burst.
- R9: Bits above bit 1 of `word_addr` change only on a load. After four steps the address returns to the start address, with no carry into the upper bits.
- R10: On an edge with no effective strobe and `adv_n` high, `word_addr` keeps its value.
- R11: `burst_start` is 1 only in the cycle right after a load edge. It is 0 after every step edge and every hold edge.
- R12: A load takes priority over an advance in the same cycle. The burst restarts at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; all inputs are sampled on it |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W (17) | Start address offered for a load |
| strb_proc_n | input | 1 | Processor address strobe, active low, qualified by `sel_n` |
| strb_ctrl_n | input | 1 | Controller address strobe, active low, lower priority |
| adv_n | input | 1 | Advance to the next beat, active low |
| sel_n | input | 1 | Chip select, active low; gates the processor strobe |
| order_sel | input | 1 | Burst order taken at load: 0 linear, 1 interleaved |
| word_addr | output | ADDR_W (17) | Current full word address |
| burst_start | output | 1 | High for the cycle in which a newly loaded address is shown |

## Verification
The two load paths can be active in the same clock. The advance can also arrive in the cycle that loads. The bench drives both strobes low together with `sel_n` low, and again with `sel_n` high. It also drives a strobe and a low `adv_n` together. The start address differs each time from the address held before. In every such cycle, the behavioural model decides which single action should win. The address and flag are then compared against that model a quarter period after the edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD      = 2'd0,
        CMD_STEP      = 2'd1,
        CMD_LOAD_PROC = 2'd2,
        CMD_LOAD_CTRL = 2'd3
    } burst_cmd_e;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] start_lo;
        logic [BEAT_W-1:0] beat;
        burst_order_e      order;
    } beat_state_t;

    function automatic logic is_load(input burst_cmd_e c);
        return (c == CMD_LOAD_PROC) || (c == CMD_LOAD_CTRL);
    endfunction

    function automatic logic [BEAT_W-1:0] map_beat(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input burst_order_e      ord
    );
        logic [BEAT_W-1:0] r;
        if (ord == ORDER_INTERLEAVED) r = start ^ beat;
        else                          r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       strb_proc_n,
    input  logic       strb_ctrl_n,
    input  logic       adv_n,
    input  logic       sel_n,
    output burst_cmd_e cmd
);
    logic proc_ok;

    always_comb begin
        proc_ok = !strb_proc_n && !sel_n;
        if (proc_ok)           cmd = CMD_LOAD_PROC;
        else if (!strb_ctrl_n) cmd = CMD_LOAD_CTRL;
        else if (!adv_n)       cmd = CMD_STEP;
        else                   cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [BEAT_W-1:0] addr_lo,
    input  burst_order_e      order_in,
    output beat_state_t       state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '{start_lo: '0, beat: '0, order: ORDER_LINEAR};
        end else if (is_load(cmd)) begin
            state <= '{start_lo: addr_lo, beat: '0, order: order_in};
        end else if (cmd == CMD_STEP) begin
            state.beat <= state.beat + 1'b1;
        end
    end

    // R6
    step_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (state.beat == BEAT_W'($past(state.beat) + 1'b1)));

    // R8
    order_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !is_load(cmd) |=> (state.order == $past(state.order)));

    // R12
    load_clears_beat_chk: assert property (@(posedge clk) disable iff (rst)
        is_load(cmd) |=> (state.beat == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int HI_W = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  burst_cmd_e      cmd,
    input  logic [HI_W-1:0] addr_hi,
    output logic [HI_W-1:0] base_hi,
    output logic            started
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            started <= 1'b0;
        end else begin
            started <= is_load(cmd);
            if (is_load(cmd)) base_hi <= addr_hi;
        end
    end

    // R9
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !is_load(cmd) |=> $stable(base_hi));

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP || cmd == CMD_HOLD) |=> !started);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              sel_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] word_addr,
    output logic              burst_start
);
    localparam int HI_W = ADDR_W - BEAT_W;

    burst_cmd_e        cmd;
    beat_state_t       bstate;
    logic [HI_W-1:0]   base_hi;
    logic [BEAT_W-1:0] cur_lo;

    burst_cmd_decode i_decode (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .sel_n       (sel_n),
        .cmd         (cmd)
    );

    burst_beat_counter i_beat (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_lo  (addr_in[BEAT_W-1:0]),
        .order_in (burst_order_e'(order_sel)),
        .state    (bstate)
    );

    burst_base_reg #(.HI_W(HI_W)) i_base (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_hi (addr_in[ADDR_W-1:BEAT_W]),
        .base_hi (base_hi),
        .started (burst_start)
    );

    always_comb begin
        cur_lo    = map_beat(bstate.start_lo, bstate.beat, bstate.order);
        word_addr = {base_hi, cur_lo};
    end

    // R2
    proc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_proc_n && !sel_n) |=> (word_addr == $past(addr_in)) && burst_start);

    // R3
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ((strb_proc_n || sel_n) && !strb_ctrl_n) |=> (word_addr == $past(addr_in)) && burst_start);

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ((strb_proc_n || sel_n) && strb_ctrl_n && adv_n) |=> $stable(word_addr) && !burst_start);

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((strb_proc_n || sel_n) && strb_ctrl_n && !adv_n && bstate.order == ORDER_LINEAR)
        |=> (word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + 1'b1)));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int ADDR_W     = 17;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strb_proc_n = 1'b1;
    logic              strb_ctrl_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              sel_n = 1'b1;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] word_addr;
    logic              burst_start;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int m_hi = 0, m_start = 0, m_beat = 0, m_order = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .adv_n(adv_n), .sel_n(sel_n), .order_sel(order_sel),
        .word_addr(word_addr), .burst_start(burst_start)
    );

    function automatic int exp_addr();
        int lo;
        if (m_order != 0) lo = m_start ^ m_beat;
        else              lo = (m_start + m_beat) % 4;
        return m_hi * 4 + lo;
    endfunction

    task automatic compare(input string tag);
        int ea;
        ea = exp_addr();
        n_vec++;
        if (word_addr !== ADDR_W'(ea) || burst_start !== (m_flag != 0)) begin
            n_bad++;
            $display("FAIL %s: addr=%h start=%b expected addr=%h start=%0d",
                     tag, word_addr, burst_start, ADDR_W'(ea), m_flag);
        end
    endtask

    task automatic apply(input logic p_n, input logic c_n, input logic a_n,
                         input logic s_n, input logic md,
                         input logic [ADDR_W-1:0] a, input string tag);
        bit ld;
        strb_proc_n = p_n; strb_ctrl_n = c_n; adv_n = a_n;
        sel_n = s_n; order_sel = md; addr_in = a;
        @(posedge clk);
        ld = (!p_n && !s_n) || !c_n;
        if (ld) begin
            m_hi = int'(a) / 4; m_start = int'(a) % 4;
            m_beat = 0; m_order = md;
        end else if (!a_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        m_flag = ld;
        #(CLK_PERIOD/4);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        compare("R1 reset");
        rst = 1'b0;

        // R2 processor load, then R6 linear steps and R9 wrap
        apply(0, 1, 1, 0, 0, 17'h1ABCE, "R2 proc load");
        for (int k = 0; k < 6; k++) apply(1, 1, 0, 0, 0, 17'h00000, "R6 R9 linear step");

        // R10 hold with changing address bus
        for (int k = 0; k < 3; k++) apply(1, 1, 1, 0, 1, ADDR_W'(k * 5 + 3), "R10 hold");

        // R3 controller load, R7 interleaved
        apply(1, 0, 1, 1, 1, 17'h0F0F1, "R3 ctrl load");
        for (int k = 0; k < 5; k++) apply(1, 1, 0, 1, 1, 17'h1FFFF, "R7 interleave step");

        // R8 order change mid-burst
        apply(0, 1, 1, 0, 0, 17'h12343, "R8 load linear");
        for (int k = 0; k < 4; k++) apply(1, 1, 0, 1, k[0], 17'h0, "R8 order toggle");

        // R5 processor strobe ignored with select high
        apply(0, 1, 1, 1, 1, 17'h05550, "R5 ignored hold");
        apply(0, 1, 0, 1, 0, 17'h0AAA2, "R5 ignored step");

        // R4 both strobes, select active and inactive
        apply(0, 0, 1, 0, 1, 17'h13572, "R4 both sel low");
        apply(1, 1, 0, 0, 0, 17'h0, "R4 step after");
        apply(0, 0, 1, 1, 0, 17'h02461, "R4 both sel high");

        // R12 load together with advance
        apply(1, 1, 0, 0, 0, 17'h0, "R12 step before");
        apply(1, 0, 0, 0, 1, 17'h1C003, "R12 load with adv");
        apply(0, 1, 0, 0, 0, 17'h0B0B2, "R12 proc load with adv");

        // R9 top address wraps without carry
        apply(0, 1, 1, 0, 0, 17'h1FFFF, "R9 top load");
        for (int k = 0; k < 4; k++) apply(1, 1, 0, 0, 0, 17'h0, "R9 top wrap");

        // R11 mixed traffic
        for (int k = 0; k < 300; k++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            apply(r[0] | r[1], r[2] | r[1], r[3], $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, ADDR_W'($urandom), "R11 mixed");
        end

        // R1 reset again mid-burst
        rst = 1'b1;
        @(posedge clk);
        m_hi = 0; m_start = 0; m_beat = 0; m_order = 0; m_flag = 0;
        #(CLK_PERIOD/4);
        compare("R1 reset again");
        rst = 1'b0;
        apply(1, 1, 0, 0, 1, 17'h0, "R1 linear after reset");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule